// File: doc/BRIEF.md
# Turnaround-free pipelined synchronous SRAM

This block is a single-port synchronous memory whose command path is pipelined two stages deep. A command is taken on a rising clock edge. Its data moves two clock edges later, for reads and for writes alike. Because reads and writes share that same two-edge distance, the shared data bus can change direction between any two commands with no idle slot in between. The data bus is split into an input half and an output half with a separate drive enable, ready to be tied to a pad ring or to an internal tri-state net.

A load cycle takes a new address and operation when all three chip selects are active. An advance cycle continues the last loaded operation on the next beat of a four-word burst. The burst follows either a linear order or an interleaved order. A suspend input freezes the whole pipeline. An asynchronous output-enable input can release the bus at any moment. Each 9-bit byte lane has its own write enable. A read that targets a word whose write is still in flight returns the new data.

Top module: `pipe_sram`

## Requirements
- R1: A load cycle with readNotWrite=1 and all selects active makes the word at that address appear on dataOut, with dataOutEn=1, during the cycle that ends at the second unsuspended clock edge after the command. A write command takes its word from dataIn at the second unsuspended edge after the command.
- R2: Reads and writes may be issued on every cycle in any mix. A read issued directly after a write to the same address returns the freshly written lanes.
- R3: While suspend=1, every other input is ignored, the pipeline and burst state hold, no word is written, and dataOut and dataOutEn keep their values.
- R4: A load cycle in which any select is inactive starts no operation. The selects are chipSelN0 (active low), chipSel1 (active high) and chipSelN2 (active low). Commands already in the pipeline still complete.
- R5: An advance cycle (advance=1) repeats the last loaded operation type on the next beat address and ignores the selects and readNotWrite. After a load that started no operation, advance cycles start none either.
- R6: With burstLinear=1, beat k (k=0..3, counting the load as beat 0) uses the address whose two low bits are (base+k) mod 4. The upper bits stay unchanged.
- R7: With burstLinear=0, beat k uses the low address bits base XOR k.
- R8: dataOutEn is 0 at the second unsuspended edge after a write command or a deselected load.
- R9: outEnN=1 forces dataOutEn to 0 at once, within the same cycle, and leaves the pipeline undisturbed.
- R10: byteWrN[b]=0 enables write lane b, which is data bits 9b+8 down to 9b. The enables are sampled in the load or advance cycle of each beat, and a disabled lane keeps its old contents.
- R11: During reset and right after it, the pipeline is empty and dataOutEn is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| suspend | input | 1 | 1 freezes the pipeline |
| chipSelN0 | input | 1 | Select, active low |
| chipSel1 | input | 1 | Select, active high |
| chipSelN2 | input | 1 | Select, active low |
| advance | input | 1 | 1 = next burst beat, 0 = load new command |
| readNotWrite | input | 1 | 1 = read, 0 = write |
| byteWrN | input | BYTES | Per-lane write enable, active low |
| burstLinear | input | 1 | 1 = linear order, 0 = interleaved order |
| addr | input | ADDR_W | Word address |
| outEnN | input | 1 | Asynchronous output enable, active low |
| dataIn | input | 9*BYTES | Write data bus |
| dataOut | output | 9*BYTES | Read data bus |
| dataOutEn | output | 1 | Drive enable for dataOut |

## Verification
Two functions can land on the same clock edge. One is the commit of a write that sits in the last pipeline stage. The other is the array read for a command one stage behind it. When both use the same address, the read must merge the write's enabled lanes from dataIn. The bench provokes this with directed write-then-read pairs, with masked lanes, and with random streams over a small address pool, and it also places suspend cycles between the two. Every read beat is compared against a reference array that applies each write before serving the read on the same edge, and dataOutEn is compared on every cycle.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;
  localparam int LANE_W = 9;
  localparam int BEAT_W = 2;

  typedef struct packed {
    logic step;
    logic rdEn;
    logic wrEn;
    logic fwd;
  } sram_strobe_t;
endpackage

// File: rtl/pipe_sram_ctrl.sv
module pipe_sram_ctrl
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              suspend,
  input  logic              chipSelN0,
  input  logic              chipSel1,
  input  logic              chipSelN2,
  input  logic              advance,
  input  logic              readNotWrite,
  input  logic [BYTES-1:0]  byteWrN,
  input  logic              burstLinear,
  input  logic [ADDR_W-1:0] addr,
  output sram_strobe_t      strb,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [BYTES-1:0]  wrMask,
  output logic              driveOn
);
  typedef struct packed {
    logic              v;
    logic              w;
    logic [ADDR_W-1:0] a;
    logic [BYTES-1:0]  m;
  } op_t;

  op_t st1, st2, nxtOp;
  logic [ADDR_W-1:0] burstBase;
  logic [BEAT_W-1:0] beatCnt, beatNext, beatLow;
  logic              burstWr, burstLive, selAll;

  assign selAll   = !chipSelN0 && chipSel1 && !chipSelN2;
  assign beatNext = beatCnt + 1'b1;

  // burst ordering: wrap-around add or XOR on the two low address bits
  always_comb begin
    if (burstLinear) beatLow = burstBase[BEAT_W-1:0] + beatNext;
    else             beatLow = burstBase[BEAT_W-1:0] ^ beatNext;
  end

  always_comb begin
    if (!advance) begin
      nxtOp.v = selAll;
      nxtOp.w = !readNotWrite;
      nxtOp.a = addr;
    end else begin
      nxtOp.v = burstLive;
      nxtOp.w = burstWr;
      nxtOp.a = {burstBase[ADDR_W-1:BEAT_W], beatLow};
    end
    nxtOp.m = ~byteWrN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st1       <= '0;
      st2       <= '0;
      burstBase <= '0;
      beatCnt   <= '0;
      burstWr   <= 1'b0;
      burstLive <= 1'b0;
    end else if (!suspend) begin
      st1 <= nxtOp;
      st2 <= st1;
      if (!advance) begin
        burstBase <= addr;
        beatCnt   <= '0;
        burstWr   <= !readNotWrite;
        burstLive <= selAll;
      end else begin
        beatCnt <= beatNext;
      end
    end
  end

  always_comb begin
    strb.step = !suspend;
    strb.rdEn = st1.v && !st1.w;
    strb.wrEn = st2.v && st2.w;
    strb.fwd  = st2.v && st2.w && (st2.a == st1.a);
  end

  assign rdAddr  = st1.a;
  assign wrAddr  = st2.a;
  assign wrMask  = st2.m;
  assign driveOn = st2.v && !st2.w;
endmodule

// File: rtl/pipe_sram_dpath.sv
module pipe_sram_dpath
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  sram_strobe_t              strb,
  input  logic [ADDR_W-1:0]         rdAddr,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [BYTES-1:0]          wrMask,
  input  logic [BYTES*LANE_W-1:0]   dataIn,
  output logic [BYTES*LANE_W-1:0]   dataOut
);
  localparam int DATA_W = BYTES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdWord, outReg;
  wire  [DATA_W-1:0] merged;

  assign rdWord = mem[rdAddr];

  // per-lane bypass of a write committing on the same edge
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = (strb.fwd && wrMask[g])
                                      ? dataIn[g*LANE_W +: LANE_W]
                                      : rdWord[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (strb.step && strb.wrEn) begin
      for (int b = 0; b < BYTES; b++) begin
        if (wrMask[b]) mem[wrAddr][b*LANE_W +: LANE_W] <= dataIn[b*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        outReg <= '0;
    else if (strb.step && strb.rdEn)  outReg <= merged;
  end

  assign dataOut = outReg;
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    suspend,
  input  logic                    chipSelN0,
  input  logic                    chipSel1,
  input  logic                    chipSelN2,
  input  logic                    advance,
  input  logic                    readNotWrite,
  input  logic [BYTES-1:0]        byteWrN,
  input  logic                    burstLinear,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    outEnN,
  input  logic [BYTES*LANE_W-1:0] dataIn,
  output logic [BYTES*LANE_W-1:0] dataOut,
  output logic                    dataOutEn
);
  localparam int DATA_W = BYTES * LANE_W;

  sram_strobe_t      strb;
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic [BYTES-1:0]  wrMask;
  logic              driveOn;

  pipe_sram_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .suspend(suspend),
    .chipSelN0(chipSelN0), .chipSel1(chipSel1), .chipSelN2(chipSelN2),
    .advance(advance), .readNotWrite(readNotWrite), .byteWrN(byteWrN),
    .burstLinear(burstLinear), .addr(addr), .strb(strb),
    .rdAddr(rdAddr), .wrAddr(wrAddr), .wrMask(wrMask), .driveOn(driveOn)
  );

  pipe_sram_dpath #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .rdAddr(rdAddr), .wrAddr(wrAddr),
    .wrMask(wrMask), .dataIn(dataIn), .dataOut(dataOut)
  );

  // asynchronous release of the bus
  assign dataOutEn = driveOn && !outEnN;
endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              suspend,
  input logic              advance,
  input logic              readNotWrite,
  input logic              chipSelN0,
  input logic              chipSel1,
  input logic              chipSelN2,
  input logic              driveOn,
  input logic [DATA_W-1:0] dataOut
);
  logic selAll, issueRd, issueQuiet, issueDesel;
  logic prevRd, prevQuiet, prevDesel, deadBeat;

  assign selAll     = !chipSelN0 && chipSel1 && !chipSelN2;
  assign issueRd    = !suspend && !advance && selAll && readNotWrite;
  assign issueQuiet = !suspend && !advance && (!selAll || !readNotWrite);
  assign issueDesel = !suspend && !advance && !selAll;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRd    <= 1'b0;
      prevQuiet <= 1'b0;
      prevDesel <= 1'b0;
      deadBeat  <= 1'b0;
    end else begin
      prevRd    <= issueRd;
      prevQuiet <= issueQuiet;
      prevDesel <= issueDesel;
      deadBeat  <= prevDesel && !suspend && advance;
    end
  end

  assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    suspend |=> $stable(dataOut));

  assert_drive_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    suspend |=> $stable(driveOn));

  assert_read_drives_R1: assert property (@(posedge clk) disable iff (!rstN)
    prevRd && !suspend |=> driveOn);

  // covers R4 as well: a deselected load releases the bus
  assert_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    prevQuiet && !suspend |=> !driveOn);

  assert_dead_burst_R5: assert property (@(posedge clk) disable iff (!rstN)
    deadBeat && !suspend |=> !driveOn);

  assert_reset_quiet_R11: assert property (@(posedge clk)
    $rose(rstN) |-> !driveOn);
endmodule

bind pipe_sram pipe_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .suspend(suspend), .advance(advance),
  .readNotWrite(readNotWrite), .chipSelN0(chipSelN0), .chipSel1(chipSel1),
  .chipSelN2(chipSelN2), .driveOn(driveOn), .dataOut(dataOut)
);

// File: tb/pipe_sram_bench.sv
`timescale 1ns/1ps
module pipe_sram_bench;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int LW = 9;
  localparam int DW = NB * LW;
  localparam int DEPTH = 1 << AW;
  localparam real TCK = 4.0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic suspend = 1'b0, chipSelN0 = 1'b1, chipSel1 = 1'b0, chipSelN2 = 1'b1;
  logic advance = 1'b0, readNotWrite = 1'b1, burstLinear = 1'b1, outEnN = 1'b0;
  logic [NB-1:0] byteWrN = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dataIn = '0;
  wire  [DW-1:0] dataOut;
  wire           dataOutEn;

  always #(TCK/2) clk = ~clk;

  pipe_sram #(.ADDR_W(AW), .BYTES(NB)) u_pipe_sram (
    .clk(clk), .rstN(rstN), .suspend(suspend), .chipSelN0(chipSelN0),
    .chipSel1(chipSel1), .chipSelN2(chipSelN2), .advance(advance),
    .readNotWrite(readNotWrite), .byteWrN(byteWrN), .burstLinear(burstLinear),
    .addr(addr), .outEnN(outEnN), .dataIn(dataIn), .dataOut(dataOut),
    .dataOutEn(dataOutEn)
  );

  typedef struct packed {
    logic          v;
    logic          w;
    logic [AW-1:0] a;
    logic [NB-1:0] m;
  } mop_t;

  mop_t          m1 = '0, m2 = '0;
  logic [DW-1:0] refMem [DEPTH];
  logic [DW-1:0] expOut = '0;
  logic [AW-1:0] bBase = '0;
  logic [1:0]    bCnt = '0;
  logic          bW = 1'b0, bLive = 1'b0;
  int            vecs = 0, errs = 0;
  string         tag = "R11";
  bit            curLin = 1'b1;

  function automatic logic [DW-1:0] rnd();
    logic [63:0] t;
    t = {$urandom, $urandom};
    return t[DW-1:0];
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  // One clock cycle: drive, check the state left by the previous edge, model the edge.
  task automatic cyc(input bit susp, input bit adv, input bit rnw, input int desel,
                     input bit lin, input bit oeN, input logic [AW-1:0] a,
                     input logic [NB-1:0] bwN);
    mop_t nop;
    logic [1:0] lo;
    bit expDrv;
    @(negedge clk);
    suspend = susp; advance = adv; readNotWrite = rnw;
    chipSelN0 = (desel == 1); chipSel1 = (desel != 2); chipSelN2 = (desel == 3);
    burstLinear = lin; outEnN = oeN; addr = a; byteWrN = bwN; dataIn = rnd();
    #1;
    expDrv = m2.v && !m2.w && !oeN;
    vecs++;
    if (dataOutEn !== expDrv) begin
      errs++;
      $display("FAIL R8 [%s] t=%0t dataOutEn=%0b expected %0b", tag, $time, dataOutEn, expDrv);
    end
    if (m2.v && !m2.w) begin
      vecs++;
      if (dataOut !== expOut) begin
        errs++;
        $display("FAIL %s read addr=%0d dataOut=%h expected %h", tag, m2.a, dataOut, expOut);
      end
    end
    @(posedge clk);
    if (!susp) begin
      if (m2.v && m2.w)
        for (int b = 0; b < NB; b++)
          if (m2.m[b]) refMem[m2.a][b*LW +: LW] = dataIn[b*LW +: LW];
      if (m1.v && !m1.w) expOut = refMem[m1.a];
      if (!adv) begin
        nop.v = (desel == 0); nop.w = !rnw; nop.a = a;
        bBase = a; bCnt = 2'd0; bW = !rnw; bLive = (desel == 0);
      end else begin
        bCnt = bCnt + 2'd1;
        lo = lin ? bBase[1:0] + bCnt : bBase[1:0] ^ bCnt;
        nop.v = bLive; nop.w = bW; nop.a = {bBase[AW-1:2], lo};
      end
      nop.m = ~bwN;
      m2 = m1;
      m1 = nop;
    end
  endtask

  task automatic ld(input bit rnw, input logic [AW-1:0] a, input logic [NB-1:0] bwN);
    cyc(1'b0, 1'b0, rnw, 0, curLin, 1'b0, a, bwN);
  endtask
  task automatic adv(input logic [NB-1:0] bwN);
    cyc(1'b0, 1'b1, $urandom % 2, 1 + $urandom % 3, curLin, 1'b0, AW'($urandom), bwN);
  endtask
  task automatic idle(input int code);
    cyc(1'b0, 1'b0, $urandom % 2, code, curLin, 1'b0, AW'($urandom), NB'($urandom));
  endtask
  task automatic stall();
    cyc(1'b1, $urandom % 2, $urandom % 2, $urandom % 4, curLin, 1'b0, AW'($urandom), NB'($urandom));
  endtask

  task automatic randomRun(input int n, input bit lin, input int oePct);
    for (int i = 0; i < n; i++) begin
      int r;
      logic [AW-1:0] a;
      logic [NB-1:0] bw;
      r  = $urandom % 100;
      a  = ($urandom % 2) ? AW'($urandom % 8) : AW'($urandom);
      bw = ($urandom % 2) ? '0 : NB'($urandom);
      if (r < 15)      cyc(1'b1, $urandom % 2, $urandom % 2, $urandom % 4, lin, ($urandom % 100) < oePct, a, bw);
      else if (r < 25) cyc(1'b0, 1'b0, $urandom % 2, 1 + $urandom % 3, lin, ($urandom % 100) < oePct, a, bw);
      else if (r < 60) cyc(1'b0, 1'b0, $urandom % 2, 0, lin, ($urandom % 100) < oePct, a, bw);
      else             cyc(1'b0, 1'b1, $urandom % 2, $urandom % 4, lin, ($urandom % 100) < oePct, a, bw);
    end
  endtask

  task automatic burstPair(input logic [AW-1:0] base);
    ld(1'b0, base, '0); adv('0); adv('0); adv('0);
    ld(1'b1, base, '0); adv('0); adv('0); adv('0);
  endtask

  initial begin
    #(TCK * 100000);
    errs++;
    $display("FAIL watchdog expired, run hung");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    vecs++;
    if (dataOutEn !== 1'b0) begin
      errs++;
      $display("FAIL R11 dataOutEn=%0b expected 0 in reset", dataOutEn);
    end
    rstN = 1'b1;
    tag = "R11"; idle(1); idle(2);

    tag = "R1";
    for (int a = 0; a < DEPTH; a++) ld(1'b0, AW'(a), '0);
    for (int a = 0; a < DEPTH; a++) ld(1'b1, AW'(a), '0);
    idle(1); idle(1);

    tag = "R2";
    ld(1'b0, 6'd5, '0); ld(1'b1, 6'd5, '0);
    ld(1'b1, 6'd6, '0); ld(1'b0, 6'd6, '0); ld(1'b1, 6'd6, '0); ld(1'b0, 6'd7, '0);
    idle(3); idle(3);

    tag = "R10";
    ld(1'b0, 6'd40, 2'b10); ld(1'b1, 6'd40, '0);
    ld(1'b0, 6'd40, 2'b01); ld(1'b1, 6'd40, '0);
    ld(1'b0, 6'd41, 2'b11); ld(1'b1, 6'd41, '0);
    ld(1'b0, 6'd44, 2'b01); adv(2'b10); adv(2'b11); adv(2'b00);
    ld(1'b1, 6'd44, '0); adv('0); adv('0); adv('0);
    idle(1); idle(1);

    tag = "R3";
    ld(1'b0, 6'd9, '0); stall(); stall(); ld(1'b1, 6'd9, '0); stall();
    ld(1'b1, 6'd8, '0); stall(); stall(); ld(1'b0, 6'd8, '0); stall(); ld(1'b1, 6'd8, '0);
    idle(1); stall(); idle(1); idle(1);

    tag = "R4";
    ld(1'b1, 6'd3, '0); idle(2); ld(1'b0, 6'd4, '0); idle(3); ld(1'b1, 6'd4, '0);
    idle(1); ld(1'b1, 6'd3, '0); idle(1); idle(1);

    tag = "R6"; curLin = 1'b1;
    for (int b = 0; b < 4; b++) burstPair(AW'(16 + b));
    idle(1); idle(1);

    tag = "R7"; curLin = 1'b0;
    for (int b = 0; b < 4; b++) burstPair(AW'(32 + b));
    idle(1); idle(1);

    tag = "R5"; curLin = 1'b1;
    ld(1'b1, 6'd20, '0); adv('0); idle(2); adv('0); adv('0); adv('0); idle(1); idle(1);
    ld(1'b0, 6'd22, '0); stall(); adv('0); adv('0); ld(1'b1, 6'd22, '0); adv('0); adv('0);
    idle(1); idle(1);

    tag = "R9";
    ld(1'b1, 6'd12, '0); ld(1'b1, 6'd13, '0);
    cyc(1'b0, 1'b0, 1'b1, 1, 1'b1, 1'b1, 6'd0, '0);
    cyc(1'b0, 1'b0, 1'b1, 1, 1'b1, 1'b0, 6'd0, '0);
    idle(1);
    randomRun(300, 1'b1, 20);

    tag = "R2";
    randomRun(800, 1'b1, 5);
    randomRun(800, 1'b0, 5);
    idle(1); idle(1);

    summary();
    $finish;
  end
endmodule